// File: doc/BRIEF.md
# Spare-pool health controller for a redundant device enclosure

This block watches the health of a redundant device group made of a set of data devices, one parity device and a small pool of dedicated online spares that stay idle until needed. Each member slot reports a failure with a one-cycle pulse. When a slot fails and a spare is still free, the controller takes a spare from the pool at once and asks an external data mover to rebuild that slot onto it. The request stays up until the mover acknowledges. A failure that comes in while a rebuild is running, and while a spare is still free, claims its spare at once and waits in a queue. Queued slots are served lowest index first.

Once the pool is empty, the next failure puts the group into degraded operation. One more failure after that is data loss. The controller lights exactly one of three lamps, green, amber or red, to show its state. It raises a repair request under one of two policies: preventive, which asks as soon as the pool is empty, or mandatory, which asks only once the group is degraded. A repair-done pulse refills the pool and clears every failed slot, unless data has already been lost. Only reset clears data loss.

Top module: `encl_health_ctrl`

## Requirements
- R1: After reset the mode is normal (mode code 0), the spare count equals the pool size, `rb_req` and `repair_req` are low and only the green lamp is lit.
- R2: A failure pulse on a healthy slot while the spare count is above zero lowers the count by one on the next clock. If several slots fail in the same cycle, they claim spares in ascending slot order.
- R3: A slot that has claimed a spare is presented on `rb_slot` with `rb_req` high one clock after its failure is registered, or one clock after the mover becomes free. `rb_req` and `rb_slot` hold until `rb_ack`. The clock edge that samples `rb_ack` drops `rb_req`. An `rb_ack` while `rb_req` is low has no effect.
- R4: Slots that claimed spares while a rebuild was running are rebuilt one at a time after the current acknowledge, lowest slot index first, with one idle cycle between requests.
- R5: A failure on a healthy slot while the spare count is zero moves a normal group to degraded (mode code 1).
- R6: A failure on a healthy slot while the group is degraded moves it to data loss (mode code 2). With k spares and no repair, data loss comes on failure k+2 and not before.
- R7: A failure pulse for a slot that is already failed and not yet rebuilt changes nothing.
- R8: Exactly one lamp is lit. Green means normal with spares left and no rebuild pending. Amber means normal with no spares left or with a rebuild pending. Red means degraded or data loss.
- R9: With the preventive policy (`policy_mandatory`=0), `repair_req` is high whenever the spare count is zero and data has not been lost.
- R10: With the mandatory policy (`policy_mandatory`=1), `repair_req` is high only while the group is degraded.
- R11: `repair_done`, outside data loss, sets the spare count back to the pool size, clears all failed slots and pending rebuilds, returns the mode to normal and drops `rb_req` on the next clock. Failure pulses in that same cycle are discarded.
- R12: In data loss, `rb_req` is low from the next clock on, and `repair_done`, `rb_ack` and failure pulses have no effect until reset.
- R13: The spare count never goes below zero and never exceeds the pool size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_pulse | input | N_DATA+1 | One-cycle failure pulse per member slot |
| rb_ack | input | 1 | Rebuild finished, from the data mover |
| repair_done | input | 1 | One-cycle pulse: enclosure serviced, spares refilled |
| policy_mandatory | input | 1 | 0 preventive, 1 mandatory repair policy |
| rb_req | output | 1 | Rebuild request to the data mover |
| rb_slot | output | $clog2(N_DATA+1) | Slot to rebuild, valid while rb_req is high |
| spares_left | output | $clog2(N_SPARE+1) | Free spares remaining |
| mode_o | output | 2 | 0 normal, 1 degraded, 2 data loss |
| led_green | output | 1 | Healthy lamp |
| led_amber | output | 1 | Warning lamp |
| led_red | output | 1 | Critical lamp |
| repair_req | output | 1 | Service request under the selected policy |

## Verification
The properties assume that `rb_ack` is a single-cycle pulse that comes only while `rb_req` is high. They also assume that `repair_done` and failure inputs are synchronous pulses, and that `policy_mandatory` changes only between scenarios. The hold-until-acknowledge property rests on the first of these assumptions. The stimulus acknowledges only a request it has seen, and it drives every input at the falling edge, one cycle wide. It still sends one stray acknowledge while the mover is idle, to show that such an acknowledge is ignored. It switches policy only while the group is in a settled state.

// File: rtl/encl_health_pkg.sv
// Package: shared types for the enclosure health controller.
// Assumes nothing beyond a 2-bit mode code seen at the top-level port.
package encl_health_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_DEGRADED = 2'd1,
        MODE_LOSS     = 2'd2
    } encl_mode_t;
endpackage

// File: rtl/encl_fail_tracker.sv
// Failure tracker: holds the failed-slot mask, the spare-claimed (pending
// rebuild) mask, the free spare count and the group mode.
// Assumes fail pulses are synchronous and done_vld only names a pending slot.
module encl_fail_tracker
    import encl_health_pkg::*;
#(
    parameter int NSLOT   = 5,
    parameter int N_SPARE = 2,
    localparam int SW     = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CW     = $clog2(N_SPARE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] fail_pulse,
    input  logic             repair_done,
    input  logic             done_vld,
    input  logic [SW-1:0]    done_slot,
    output logic [NSLOT-1:0] pend_q,
    output logic [CW-1:0]    spare_q,
    output encl_mode_t       mode_q,
    output logic             repair_take
);
    localparam logic [CW-1:0] FULL_POOL = CW'(N_SPARE);

    logic [NSLOT-1:0] failed_q, failed_n, pend_n;
    logic [CW-1:0]    spare_n;
    encl_mode_t       mode_n;

    // Repair is honoured in every mode but data loss.
    assign repair_take = repair_done && (mode_q != MODE_LOSS);

    // Next-state: rebuild completion, then repair or new failures in slot order.
    always_comb begin
        failed_n = failed_q;
        pend_n   = pend_q;
        spare_n  = spare_q;
        mode_n   = mode_q;
        if (done_vld) begin
            failed_n[done_slot] = 1'b0;
            pend_n[done_slot]   = 1'b0;
        end
        if (repair_take) begin
            failed_n = '0;
            pend_n   = '0;
            spare_n  = FULL_POOL;
            mode_n   = MODE_NORMAL;
        end else if (mode_q != MODE_LOSS) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (fail_pulse[s] && !failed_n[s] && (mode_n != MODE_LOSS)) begin
                    failed_n[s] = 1'b1;
                    if (spare_n != '0) begin
                        spare_n   = spare_n - 1'b1;
                        pend_n[s] = 1'b1;
                    end else if (mode_n == MODE_NORMAL) begin
                        mode_n = MODE_DEGRADED;
                    end else begin
                        mode_n = MODE_LOSS;
                    end
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            failed_q <= '0;
            pend_q   <= '0;
            spare_q  <= FULL_POOL;
            mode_q   <= MODE_NORMAL;
        end else begin
            failed_q <= failed_n;
            pend_q   <= pend_n;
            spare_q  <= spare_n;
            mode_q   <= mode_n;
        end
    end
endmodule

// File: rtl/encl_rebuild_seq.sv
// Rebuild sequencer: issues one request/acknowledge rebuild at a time to the
// external data mover, choosing the lowest pending slot when idle.
// Assumes rb_ack is a single-cycle pulse; an ack while idle is dropped.
module encl_rebuild_seq #(
    parameter int NSLOT = 5,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] pend,
    input  logic             abort,
    input  logic             rb_ack,
    output logic             busy_q,
    output logic [SW-1:0]    slot_q,
    output logic             done_vld
);
    logic [SW-1:0] pick;

    // Lowest-index pending slot; scanning downward lets the lowest win.
    always_comb begin
        pick = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (pend[s]) pick = SW'(s);
        end
    end

    // A completion counts only for a live, unaborted request.
    assign done_vld = busy_q && rb_ack && !abort;

    // Request register: start, hold until ack, or drop on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (rb_ack) busy_q <= 1'b0;
        end else if (|pend) begin
            busy_q <= 1'b1;
            slot_q <= pick;
        end
    end
endmodule

// File: rtl/encl_status_map.sv
// Status map: turns mode, spare count and pending rebuilds into the three
// lamps and the policy-dependent repair request. Purely combinational.
module encl_status_map
    import encl_health_pkg::*;
#(
    parameter int N_SPARE = 2,
    localparam int CW     = $clog2(N_SPARE + 1)
) (
    input  encl_mode_t    mode,
    input  logic [CW-1:0] spares,
    input  logic          rebuild_any,
    input  logic          policy_mandatory,
    output logic          led_green,
    output logic          led_amber,
    output logic          led_red,
    output logic          repair_req
);
    logic is_norm, pool_empty;

    // Decode shared terms.
    always_comb begin
        is_norm    = (mode == MODE_NORMAL);
        pool_empty = (spares == '0);
    end

    // Lamp selection: red dominates, amber for warning, green otherwise.
    always_comb begin
        led_red   = !is_norm;
        led_amber = is_norm && (pool_empty || rebuild_any);
        led_green = is_norm && !pool_empty && !rebuild_any;
    end

    // Repair request per policy; never after data loss.
    always_comb begin
        if (mode == MODE_LOSS)
            repair_req = 1'b0;
        else if (policy_mandatory)
            repair_req = (mode == MODE_DEGRADED);
        else
            repair_req = pool_empty;
    end
endmodule

// File: rtl/encl_health_ctrl.sv
// Enclosure health controller top: joins the failure tracker, the rebuild
// sequencer and the status map. N_DATA data slots plus one parity slot are
// monitored; N_SPARE idle spares form the pool.
module encl_health_ctrl
    import encl_health_pkg::*;
#(
    parameter int N_DATA  = 4,
    parameter int N_SPARE = 2,
    localparam int NSLOT  = N_DATA + 1,
    localparam int SW     = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CW     = $clog2(N_SPARE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] fail_pulse,
    input  logic             rb_ack,
    input  logic             repair_done,
    input  logic             policy_mandatory,
    output logic             rb_req,
    output logic [SW-1:0]    rb_slot,
    output logic [CW-1:0]    spares_left,
    output logic [1:0]       mode_o,
    output logic             led_green,
    output logic             led_amber,
    output logic             led_red,
    output logic             repair_req
);
    logic [NSLOT-1:0] pend;
    logic [CW-1:0]    spare_q;
    encl_mode_t       mode_q;
    logic             repair_take, done_vld, abort;
    logic [SW-1:0]    slot_q;
    logic             busy_q;

    // Abort in-flight rebuilds on an accepted repair or after data loss.
    assign abort = repair_take || (mode_q == MODE_LOSS);

    encl_fail_tracker #(.NSLOT(NSLOT), .N_SPARE(N_SPARE)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .fail_pulse  (fail_pulse),
        .repair_done (repair_done),
        .done_vld    (done_vld),
        .done_slot   (slot_q),
        .pend_q      (pend),
        .spare_q     (spare_q),
        .mode_q      (mode_q),
        .repair_take (repair_take)
    );

    encl_rebuild_seq #(.NSLOT(NSLOT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .abort    (abort),
        .rb_ack   (rb_ack),
        .busy_q   (busy_q),
        .slot_q   (slot_q),
        .done_vld (done_vld)
    );

    encl_status_map #(.N_SPARE(N_SPARE)) u_stat (
        .mode             (mode_q),
        .spares           (spare_q),
        .rebuild_any      (|pend),
        .policy_mandatory (policy_mandatory),
        .led_green        (led_green),
        .led_amber        (led_amber),
        .led_red          (led_red),
        .repair_req       (repair_req)
    );

    // Port assignments.
    assign rb_req      = busy_q;
    assign rb_slot     = slot_q;
    assign spares_left = spare_q;
    assign mode_o      = mode_q;
endmodule

// File: rtl/encl_health_chk.sv
// Checker for encl_health_ctrl, attached by bind below. Watches ports only.
// Assumes rb_ack pulses only while rb_req is high.
module encl_health_chk #(
    parameter int N_SPARE = 2,
    parameter int SW      = 3,
    parameter int CW      = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rb_ack,
    input logic          repair_done,
    input logic          policy_mandatory,
    input logic          rb_req,
    input logic [SW-1:0] rb_slot,
    input logic [CW-1:0] spares_left,
    input logic [1:0]    mode_o,
    input logic          led_green,
    input logic          led_amber,
    input logic          led_red,
    input logic          repair_req
);
    AST_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({led_green, led_amber, led_red})); // R8
    AST_SPARE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        spares_left <= CW'(N_SPARE)); // R13
    AST_SPARE_ONLY_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        !repair_done |=> spares_left <= $past(spares_left)); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_ack && !repair_done && mode_o != 2'd2) |=> (rb_req && $stable(rb_slot))); // R3
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && rb_ack) |=> !rb_req); // R3
    AST_DEGR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> (spares_left == '0)); // R5
    AST_LOSS_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> (mode_o == 2'd2)); // R12
    AST_LOSS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> !rb_req); // R12
    AST_PREVENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy_mandatory && spares_left == '0 && mode_o != 2'd2) |-> repair_req); // R9
    AST_MAND_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_mandatory && repair_req) |-> (mode_o == 2'd1)); // R10
endmodule

bind encl_health_ctrl encl_health_chk #(.N_SPARE(N_SPARE), .SW(SW), .CW(CW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rb_ack           (rb_ack),
    .repair_done      (repair_done),
    .policy_mandatory (policy_mandatory),
    .rb_req           (rb_req),
    .rb_slot          (rb_slot),
    .spares_left      (spares_left),
    .mode_o           (mode_o),
    .led_green        (led_green),
    .led_amber        (led_amber),
    .led_red          (led_red),
    .repair_req       (repair_req)
);

// File: tb/encl_health_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the DUT every clock,
// plus named scenario checks.
module encl_health_ctrl_tb;
    localparam int N_DATA  = 4;
    localparam int N_SPARE = 2;
    localparam int NSLOT   = N_DATA + 1;
    localparam int SW      = $clog2(NSLOT);
    localparam int CW      = $clog2(N_SPARE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSLOT-1:0] fail_pulse = '0;
    logic rb_ack = 1'b0, repair_done = 1'b0, policy_mandatory = 1'b0;
    logic rb_req, led_green, led_amber, led_red, repair_req;
    logic [SW-1:0] rb_slot;
    logic [CW-1:0] spares_left;
    logic [1:0] mode_o;

    int total = 0;
    int bad = 0;

    // Reference model state.
    int m_mode, m_spares, m_busy, m_slot;
    bit m_failed[NSLOT];
    bit m_pend[NSLOT];

    always #2.5 clk = ~clk;

    encl_health_ctrl #(.N_DATA(N_DATA), .N_SPARE(N_SPARE)) u_dut (
        .clk(clk), .rst_n(rst_n), .fail_pulse(fail_pulse), .rb_ack(rb_ack),
        .repair_done(repair_done), .policy_mandatory(policy_mandatory),
        .rb_req(rb_req), .rb_slot(rb_slot), .spares_left(spares_left),
        .mode_o(mode_o), .led_green(led_green), .led_amber(led_amber),
        .led_red(led_red), .repair_req(repair_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_spares = N_SPARE; m_busy = 0; m_slot = 0;
        for (int s = 0; s < NSLOT; s++) begin m_failed[s] = 0; m_pend[s] = 0; end
    endtask

    // Advance the model by one clock from the current inputs.
    task automatic model_step();
        int nb, ns, any, low;
        bit take, done;
        take = repair_done && m_mode != 2;
        done = m_busy != 0 && rb_ack && !(take || m_mode == 2);
        any = 0; low = 0;
        for (int s = NSLOT - 1; s >= 0; s--) if (m_pend[s]) begin any = 1; low = s; end
        nb = m_busy; ns = m_slot;
        if (take || m_mode == 2) nb = 0;
        else if (m_busy != 0) begin if (rb_ack) nb = 0; end
        else if (any != 0) begin nb = 1; ns = low; end
        if (done) begin m_failed[m_slot] = 0; m_pend[m_slot] = 0; end
        if (take) begin
            model_reset();
        end else if (m_mode != 2) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (fail_pulse[s] && !m_failed[s] && m_mode != 2) begin
                    m_failed[s] = 1;
                    if (m_spares > 0) begin m_spares--; m_pend[s] = 1; end
                    else m_mode = m_mode + 1;
                end
            end
        end
        m_busy = nb; m_slot = ns;
    endtask

    // Compare every output with the model.
    task automatic compare();
        int pend_any, g, a, r, rq;
        pend_any = 0;
        for (int s = 0; s < NSLOT; s++) if (m_pend[s]) pend_any = 1;
        r = (m_mode != 0);
        a = (m_mode == 0) && (m_spares == 0 || pend_any != 0);
        g = (m_mode == 0) && !(m_spares == 0 || pend_any != 0);
        rq = (m_mode == 2) ? 0 : (policy_mandatory ? (m_mode == 1) : (m_spares == 0));
        check(mode_o == m_mode, "R5/R6 mode", mode_o, m_mode);
        check(spares_left == m_spares, "R2 spares", spares_left, m_spares);
        check(rb_req == m_busy, "R3 rb_req", rb_req, m_busy);
        if (m_busy != 0) check(rb_slot == m_slot, "R4 rb_slot", rb_slot, m_slot);
        check({led_green, led_amber, led_red} == {g[0], a[0], r[0]}, "R8 lamps",
              {led_green, led_amber, led_red}, {g[0], a[0], r[0]});
        check(repair_req == rq, "R9/R10 repair_req", repair_req, rq);
    endtask

    // One clock: drive at falling edge, model at rising edge, compare at next fall.
    task automatic step(input logic [NSLOT-1:0] f, input bit ack, input bit rep);
        fail_pulse = f; rb_ack = ack; repair_done = rep;
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        fail_pulse = '0; rb_ack = 0; repair_done = 0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        step('0, 0, 0);
        step('0, 0, 0);
        rst_n = 1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(mode_o == 0 && spares_left == N_SPARE, "R1 reset", spares_left, N_SPARE);
        check(led_green && !rb_req && !repair_req, "R1 idle outputs", {led_green, rb_req, repair_req}, 3'b100);

        // R3 stray ack while idle ignored
        step('0, 1, 0);
        check(spares_left == N_SPARE && !rb_req, "R3 stray ack", rb_req, 0);

        // R2/R3 first failure on slot 2
        step(5'b00100, 0, 0);
        check(spares_left == N_SPARE - 1 && !rb_req, "R2 spare claimed", spares_left, N_SPARE - 1);
        step('0, 0, 0);
        check(rb_req && rb_slot == 2, "R3 request slot 2", rb_slot, 2);
        // R4 queued failures on 4 and 0 in one cycle: 0 takes the last spare, 4 degrades
        step(5'b10001, 0, 0);
        check(spares_left == 0 && mode_o == 1, "R5 degraded on empty pool", mode_o, 1);
        check(repair_req, "R9 preventive request", repair_req, 1);
        // R7 repeat pulse on failed slot 2 ignored
        step(5'b00100, 0, 0);
        check(mode_o == 1 && rb_slot == 2, "R7 repeat ignored", mode_o, 1);
        idle(2);
        step('0, 1, 0);
        check(!rb_req, "R3 ack drops request", rb_req, 0);
        step('0, 0, 0);
        check(rb_req && rb_slot == 0, "R4 queued slot 0 next", rb_slot, 0);
        step('0, 1, 0);
        idle(2);
        // R10 mandatory policy while degraded
        policy_mandatory = 1;
        idle(1);
        check(repair_req, "R10 mandatory when degraded", repair_req, 1);
        // R11 repair with same-cycle failure dropped
        step(5'b00010, 0, 1);
        check(mode_o == 0 && spares_left == N_SPARE && led_green, "R11 repair restores", spares_left, N_SPARE);
        // R10 normal with empty pool under mandatory: no request
        step(5'b00011, 0, 0);
        check(spares_left == 0 && !repair_req && led_amber, "R10 no request in normal", repair_req, 0);
        idle(1);
        // R11 repair aborts running rebuild
        step('0, 0, 1);
        check(!rb_req && spares_left == N_SPARE, "R11 rebuild aborted", rb_req, 0);
        idle(2);

        // R6 k+2 failures to data loss, one per cycle
        policy_mandatory = 0;
        step(5'b00001, 0, 0);
        step(5'b00010, 0, 0);
        step(5'b00100, 0, 0);
        check(mode_o == 1, "R6 k+1 failures survive", mode_o, 1);
        step(5'b01000, 0, 0);
        check(mode_o == 2 && led_red, "R6 data loss", mode_o, 2);
        idle(1);
        check(!rb_req && !repair_req, "R12 no request in loss", rb_req, 0);
        // R12 repair, ack, fail ignored in loss
        step('0, 0, 1);
        step(5'b10000, 1, 0);
        idle(2);
        check(mode_o == 2 && spares_left == 0, "R12 loss frozen", mode_o, 2);

        // R13 saturation: many pulses from fresh reset
        do_reset();
        step(5'b00111, 0, 0);
        check(spares_left == 0 && mode_o == 1, "R13 pool saturates", spares_left, 0);
        idle(3);
        step('0, 1, 0);
        idle(3);
        step('0, 1, 0);
        idle(3);
        check(mode_o == 1 && !rb_req, "R4 all rebuilt", rb_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule